// File: doc/BRIEF.md
# Two-Wire Slave Address Front-End with Dual Internal Targets

This block is the receive side of a two-wire serial slave for a small peripheral that holds two internal targets: a bank of wiper registers and a control/status register. It oversamples the clock and data lines in the system clock domain and finds START and STOP conditions. After each START it collects the address byte and decides whether to acknowledge it. The upper nibble of that byte must match a fixed device-type code. The next three bits pick the internal target. The last bit gives the transfer direction.

After an accepted write address, the block acknowledges every data byte that follows. It hands each byte to the register logic as a one-cycle strobe together with the byte value. A byte aimed at the wiper bank is passed on only while the externally held write-enable latch is set. A STOP that closes a write carrying at least one delivered data byte stands for a nonvolatile commit. A programmable busy timer then runs, and while it runs every address byte is left without an acknowledge, so the master can poll until the device answers. In a read, the front-end reports the selected target and direction and then stays passive until the next START or STOP. The read data path lives elsewhere.

Top module: `twi_dual_target_front`

## Requirements
- R1: After reset the block releases SDA (`sda_drive_low_o` = 0), reports no target (`tgt_sel_o` = 2'b00), has `rw_o` = 0, gives no strobe, and is not busy.
- R2: An address byte is acknowledged only if its bits [7:4] equal 4'b1010. The acknowledge pulls SDA low during the ninth SCL clock, and the pull-down starts only while SCL is low.
- R3: Address bits [3:1] = 3'b111 select the wiper bank (`tgt_sel_o` = 2'b01), and 3'b010 selects the control/status register (`tgt_sel_o` = 2'b10). Address bit [0] appears on `rw_o` (1 = read, 0 = write). After an accepted read address, no data byte is acknowledged or strobed.
- R4: A wrong type nibble or any other sub-address code leaves SDA released for the ninth clock and keeps `tgt_sel_o` = 2'b00. Later bytes are ignored until the next START or STOP.
- R5: Each data byte after an accepted write address is acknowledged. On the SCL fall that ends the eighth bit, the block gives a one-cycle `byte_stb_o` pulse with the byte on `byte_o`, first-received bit in bit 7.
- R6: A data byte for the wiper bank is strobed only when `wel_i` is 1. The byte is still acknowledged. Control/status writes are strobed regardless of `wel_i`.
- R7: A STOP that ends a write in which at least one byte was strobed (with no START in between) starts a busy period of BUSY_CYCLES system clocks. While busy, every address byte is left unacknowledged and no target is selected. A write with no strobed byte starts no busy period.
- R8: Once the busy period has elapsed, a valid address byte is acknowledged again.
- R9: A START in the middle of a byte restarts address collection with a fresh bit count. A STOP at any point returns the block to idle with SDA released and `tgt_sel_o` = 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| wel_i | input | 1 | Write-enable latch state; gates wiper writes |
| sda_drive_low_o | output | 1 | 1 pulls SDA low (acknowledge), 0 releases it |
| tgt_sel_o | output | 2 | Selected target: 00 none, 01 wiper bank, 10 control/status |
| rw_o | output | 1 | Direction of the accepted address: 1 read, 0 write |
| byte_stb_o | output | 1 | One-cycle strobe for a delivered data byte |
| byte_o | output | 8 | Data byte, valid with the strobe |

## Verification
The bound checker watches several rules on every cycle. The strobe is a single cycle and never comes with a read or without a target. Wiper strobes follow a set write-enable latch. `rw_o` is never set without a target. The acknowledge pull-down starts only with SCL low. A STOP releases the line and clears the target. No target can appear while busy. The directed scenarios show what needs whole bus sequences: the address decode over every reserved code, the values of delivered bytes, busy polling that fails and then succeeds, and aborts by START and STOP in the middle of a byte.

// File: rtl/twi_front_pkg.sv
package twi_front_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'b00,
    TGT_WIPER = 2'b01,
    TGT_CTRL  = 2'b10
  } tgt_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ADDR    = 3'd1,
    ST_ADDR_AK = 3'd2,
    ST_DATA    = 3'd3,
    ST_DATA_AK = 3'd4,
    ST_PASSIVE = 3'd5
  } eng_state_e;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_chain_q;
  logic [SYNC_STAGES-1:0] sda_chain_q;
  logic                   scl_prev_q;
  logic                   sda_prev_q;

  // idle lines are high, so the chains come out of reset high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_chain_q <= '1;
      sda_chain_q <= '1;
      scl_prev_q  <= 1'b1;
      sda_prev_q  <= 1'b1;
    end else begin
      scl_chain_q <= {scl_chain_q[SYNC_STAGES-2:0], scl_i};
      sda_chain_q <= {sda_chain_q[SYNC_STAGES-2:0], sda_i};
      scl_prev_q  <= scl_chain_q[SYNC_STAGES-1];
      sda_prev_q  <= sda_chain_q[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_chain_q[SYNC_STAGES-1];
  assign sda_s     = sda_chain_q[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev_q;
  assign scl_fall  = ~scl_s & scl_prev_q;
  // data edges are bus conditions only while the clock stays high
  assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

endmodule

// File: rtl/twi_addr_decode.sv
module twi_addr_decode
  import twi_front_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE  = 4'b1010,
  parameter logic [2:0] SUB_WIPER = 3'b111,
  parameter logic [2:0] SUB_CTRL  = 3'b010
) (
  input  logic [BYTE_W-1:0] addr_byte,
  output logic              hit,
  output tgt_e              tgt,
  output logic              rd
);

  logic type_ok;
  logic [2:0] sub;

  assign type_ok = (addr_byte[7:4] == DEV_TYPE);
  assign sub     = addr_byte[3:1];
  assign rd      = addr_byte[0];

  always_comb begin
    tgt = TGT_NONE;
    if (type_ok) begin
      if (sub == SUB_WIPER)     tgt = TGT_WIPER;
      else if (sub == SUB_CTRL) tgt = TGT_CTRL;
    end
  end

  assign hit = (tgt != TGT_NONE);

endmodule

// File: rtl/twi_busy_timer.sv
module twi_busy_timer #(
  parameter int BUSY_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);

  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(BUSY_CYCLES);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = load ? LOAD_VAL : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/twi_byte_engine.sv
module twi_byte_engine
  import twi_front_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              busy,
  input  logic              wel,
  input  logic              dec_hit,
  input  tgt_e              dec_tgt,
  input  logic              dec_rd,
  output logic [BYTE_W-1:0] shift_o,
  output logic              drive_low_o,
  output tgt_e              tgt_o,
  output logic              rw_o,
  output logic              stb_o,
  output logic              commit_o
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  eng_state_e        state_q, state_d;
  logic [CNT_W-1:0]  bits_q, bits_d;
  logic [BYTE_W-1:0] shift_q, shift_d;
  logic              drive_q, drive_d;
  tgt_e              tgt_q, tgt_d;
  logic              rw_q, rw_d;
  logic              stb_q, stb_d;
  logic              pend_q, pend_d;
  logic              commit_q, commit_d;
  logic              take_bit;
  logic              byte_end;
  logic              wr_allowed;

  assign take_bit   = scl_rise & (bits_q != FULL);
  assign byte_end   = scl_fall & (bits_q == FULL);
  assign wr_allowed = !((tgt_q == TGT_WIPER) && !wel);

  always_comb begin
    state_d  = state_q;
    bits_d   = bits_q;
    shift_d  = shift_q;
    drive_d  = drive_q;
    tgt_d    = tgt_q;
    rw_d     = rw_q;
    pend_d   = pend_q;
    stb_d    = 1'b0;
    commit_d = 1'b0;
    if (stop_det) begin
      state_d  = ST_IDLE;
      bits_d   = '0;
      drive_d  = 1'b0;
      tgt_d    = TGT_NONE;
      rw_d     = 1'b0;
      commit_d = pend_q;
      pend_d   = 1'b0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      bits_d  = '0;
      drive_d = 1'b0;
      tgt_d   = TGT_NONE;
      rw_d    = 1'b0;
      pend_d  = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR: begin
          if (take_bit) begin
            shift_d = {shift_q[BYTE_W-2:0], sda_s};
            bits_d  = bits_q + 1'b1;
          end else if (byte_end) begin
            if (dec_hit && !busy) begin
              drive_d = 1'b1;
              tgt_d   = dec_tgt;
              rw_d    = dec_rd;
              state_d = ST_ADDR_AK;
            end else begin
              state_d = ST_PASSIVE;
            end
          end
        end
        ST_ADDR_AK: begin
          if (scl_fall) begin
            drive_d = 1'b0;
            bits_d  = '0;
            state_d = rw_q ? ST_PASSIVE : ST_DATA;
          end
        end
        ST_DATA: begin
          if (take_bit) begin
            shift_d = {shift_q[BYTE_W-2:0], sda_s};
            bits_d  = bits_q + 1'b1;
          end else if (byte_end) begin
            drive_d = 1'b1;
            state_d = ST_DATA_AK;
            if (wr_allowed) begin
              stb_d  = 1'b1;
              pend_d = 1'b1;
            end
          end
        end
        ST_DATA_AK: begin
          if (scl_fall) begin
            drive_d = 1'b0;
            bits_d  = '0;
            state_d = ST_DATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bits_q   <= '0;
      shift_q  <= '0;
      drive_q  <= 1'b0;
      tgt_q    <= TGT_NONE;
      rw_q     <= 1'b0;
      stb_q    <= 1'b0;
      pend_q   <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      bits_q   <= bits_d;
      shift_q  <= shift_d;
      drive_q  <= drive_d;
      tgt_q    <= tgt_d;
      rw_q     <= rw_d;
      stb_q    <= stb_d;
      pend_q   <= pend_d;
      commit_q <= commit_d;
    end
  end

  assign shift_o     = shift_q;
  assign drive_low_o = drive_q;
  assign tgt_o       = tgt_q;
  assign rw_o        = rw_q;
  assign stb_o       = stb_q;
  assign commit_o    = commit_q;

endmodule

// File: rtl/twi_dual_target_front.sv
module twi_dual_target_front
  import twi_front_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         BUSY_CYCLES = 2000,
  parameter logic [3:0] DEV_TYPE    = 4'b1010,
  parameter logic [2:0] SUB_WIPER   = 3'b111,
  parameter logic [2:0] SUB_CTRL    = 3'b010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              wel_i,
  output logic              sda_drive_low_o,
  output logic [1:0]        tgt_sel_o,
  output logic              rw_o,
  output logic              byte_stb_o,
  output logic [BYTE_W-1:0] byte_o
);

  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, commit;
  logic dec_hit, dec_rd;
  tgt_e dec_tgt, tgt_q;
  logic [BYTE_W-1:0] shift_q;

  twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twi_addr_decode #(
    .DEV_TYPE  (DEV_TYPE),
    .SUB_WIPER (SUB_WIPER),
    .SUB_CTRL  (SUB_CTRL)
  ) u_dec (
    .addr_byte (shift_q),
    .hit       (dec_hit),
    .tgt       (dec_tgt),
    .rd        (dec_rd)
  );

  twi_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (commit),
    .busy  (busy)
  );

  twi_byte_engine u_eng (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .sda_s       (sda_s),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .busy        (busy),
    .wel         (wel_i),
    .dec_hit     (dec_hit),
    .dec_tgt     (dec_tgt),
    .dec_rd      (dec_rd),
    .shift_o     (shift_q),
    .drive_low_o (sda_drive_low_o),
    .tgt_o       (tgt_q),
    .rw_o        (rw_o),
    .stb_o       (byte_stb_o),
    .commit_o    (commit)
  );

  assign tgt_sel_o = tgt_q;
  assign byte_o    = shift_q;

endmodule

// File: rtl/twi_dual_target_front_chk.sv
module twi_dual_target_front_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       scl_s,
  input logic       stop_det,
  input logic       busy,
  input logic       wel_i,
  input logic       sda_drive_low_o,
  input logic [1:0] tgt_sel_o,
  input logic       rw_o,
  input logic       byte_stb_o
);

  AST_ACK_STARTS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(sda_drive_low_o) |-> !scl_s); // R2

  AST_TGT_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tgt_sel_o != 2'b11); // R3

  AST_RW_NEEDS_TARGET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rw_o |-> tgt_sel_o != 2'b00); // R3

  AST_STB_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    byte_stb_o |=> !byte_stb_o); // R5

  AST_STB_ON_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    byte_stb_o |-> (tgt_sel_o != 2'b00 && !rw_o)); // R5

  AST_WIPER_STB_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (byte_stb_o && tgt_sel_o == 2'b01) |-> $past(wel_i)); // R6

  AST_BUSY_BLOCKS_TARGET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && tgt_sel_o == 2'b00) |=> tgt_sel_o == 2'b00); // R7

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stop_det |=> (!sda_drive_low_o && tgt_sel_o == 2'b00)); // R9

endmodule

bind twi_dual_target_front twi_dual_target_front_chk u_chk (
  .clk             (clk),
  .rst_sync_n      (rst_sync_n),
  .scl_s           (scl_s),
  .stop_det        (stop_det),
  .busy            (busy),
  .wel_i           (wel_i),
  .sda_drive_low_o (sda_drive_low_o),
  .tgt_sel_o       (tgt_sel_o),
  .rw_o            (rw_o),
  .byte_stb_o      (byte_stb_o)
);

// File: tb/twi_dual_target_front_bench.sv
`timescale 1ns/1ps
module twi_dual_target_front_bench;

  localparam int Q    = 10;
  localparam int BUSY = 1500;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_m, sda_m, wel;
  logic       drive_low, rw, stb;
  logic [1:0] tgt;
  logic [7:0] bval;
  logic       sda_line;

  int vectors = 0;
  int fails   = 0;
  int stb_cnt = 0;
  logic [7:0] last_byte = 8'h00;

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~drive_low;

  twi_dual_target_front #(.BUSY_CYCLES(BUSY)) u_twi_dual_target_front (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_i           (scl_m),
    .sda_i           (sda_line),
    .wel_i           (wel),
    .sda_drive_low_o (drive_low),
    .tgt_sel_o       (tgt),
    .rw_o            (rw),
    .byte_stb_o      (stb),
    .byte_o          (bval)
  );

  always @(posedge clk) begin
    if (rst_n && stb) begin
      stb_cnt   <= stb_cnt + 1;
      last_byte <= bval;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b;    wq(Q);
    scl_m = 1'b1; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q/2);
    acked = ~sda_line;
    wq(Q/2);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic t_reset();
    chk(drive_low == 1'b0, "R1", "sda released", drive_low, 0);
    chk(tgt == 2'b00, "R1", "no target", tgt, 0);
    chk(rw == 1'b0, "R1", "rw clear", rw, 0);
    chk(stb_cnt == 0, "R1", "no strobe", stb_cnt, 0);
  endtask

  // control write starts a busy period; polling NAKs until it ends
  task automatic t_ctrl_write_and_poll();
    logic a;
    wel = 1'b0; stb_cnt = 0;
    bus_start();
    send_byte(8'hA4, a);
    chk(a == 1'b1, "R2", "ctrl write addr ack", a, 1);
    chk(tgt == 2'b10, "R3", "ctrl target", tgt, 2);
    chk(rw == 1'b0, "R3", "write flag", rw, 0);
    send_byte(8'h3C, a);
    chk(a == 1'b1, "R5", "data ack", a, 1);
    chk(stb_cnt == 1, "R6", "ctrl strobe ignores wel", stb_cnt, 1);
    chk(last_byte == 8'h3C, "R5", "data value", last_byte, 8'h3C);
    bus_stop();
    chk(tgt == 2'b00 && drive_low == 1'b0, "R9", "idle after stop", tgt, 0);
    bus_start();
    send_byte(8'hAE, a);
    chk(a == 1'b0, "R7", "poll nak while busy", a, 0);
    chk(tgt == 2'b00, "R7", "no target while busy", tgt, 0);
    bus_stop();
    wq(BUSY);
    bus_start();
    send_byte(8'hAE, a);
    chk(a == 1'b1, "R8", "ack after busy", a, 1);
    chk(tgt == 2'b01, "R8", "wiper target after busy", tgt, 1);
    bus_stop();
  endtask

  task automatic t_wiper_gate();
    logic a;
    wel = 1'b0; stb_cnt = 0;
    bus_start();
    send_byte(8'hAE, a);
    chk(a == 1'b1, "R3", "wiper addr ack", a, 1);
    chk(tgt == 2'b01, "R3", "wiper target", tgt, 1);
    send_byte(8'h81, a);
    chk(a == 1'b1, "R6", "gated byte still acked", a, 1);
    chk(stb_cnt == 0, "R6", "no strobe without wel", stb_cnt, 0);
    bus_stop();
    bus_start();
    send_byte(8'hAE, a);
    chk(a == 1'b1, "R7", "no busy after unstrobed write", a, 1);
    bus_stop();
  endtask

  task automatic t_wiper_write();
    logic a;
    wel = 1'b1; stb_cnt = 0;
    bus_start();
    send_byte(8'hAE, a);
    chk(a == 1'b1, "R2", "wiper addr ack", a, 1);
    send_byte(8'h5A, a);
    chk(last_byte == 8'h5A, "R5", "first byte", last_byte, 8'h5A);
    send_byte(8'hC3, a);
    chk(a == 1'b1, "R5", "second ack", a, 1);
    chk(stb_cnt == 2, "R6", "two strobes with wel", stb_cnt, 2);
    chk(last_byte == 8'hC3, "R5", "second byte", last_byte, 8'hC3);
    bus_stop();
    wel = 1'b0;
    wq(BUSY + 20);
  endtask

  task automatic t_ctrl_read();
    logic a;
    stb_cnt = 0;
    bus_start();
    send_byte(8'hA5, a);
    chk(a == 1'b1, "R3", "read addr ack", a, 1);
    chk(tgt == 2'b10 && rw == 1'b1, "R3", "ctrl read flags", {tgt, rw}, 5);
    send_byte(8'h77, a);
    chk(a == 1'b0 && stb_cnt == 0, "R3", "read phase passive", {a, stb_cnt[0]}, 0);
    bus_stop();
  endtask

  task automatic t_bad_type();
    logic a;
    stb_cnt = 0;
    bus_start();
    send_byte(8'hBE, a);
    chk(a == 1'b0, "R2", "wrong type nak", a, 0);
    chk(tgt == 2'b00, "R4", "wrong type no target", tgt, 0);
    send_byte(8'h11, a);
    chk(a == 1'b0 && stb_cnt == 0, "R4", "bytes ignored", {a, stb_cnt[0]}, 0);
    bus_stop();
  endtask

  task automatic t_reserved();
    logic a;
    for (int s = 0; s < 8; s++) begin
      if (s != 7 && s != 2) begin
        bus_start();
        send_byte({4'b1010, 3'(s), 1'b0}, a);
        chk(a == 1'b0 && tgt == 2'b00, "R4", $sformatf("reserved sub %0d", s),
            {a, tgt}, 0);
        bus_stop();
      end
    end
  endtask

  task automatic t_abort();
    logic a;
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_start();
    send_byte(8'hA4, a);
    chk(a == 1'b1 && tgt == 2'b10, "R9", "restart mid-byte", {a, tgt}, 6);
    bus_stop();
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    scl_m = 1'b0; wq(Q);
    bus_stop();
    chk(tgt == 2'b00 && drive_low == 1'b0, "R9", "stop mid-byte idle", tgt, 0);
    bus_start();
    send_byte(8'hAE, a);
    chk(a == 1'b1, "R9", "clean after stop abort", a, 1);
    bus_stop();
  endtask

  initial begin
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; wel = 1'b0;
    wq(5);
    rst_n = 1'b1;
    wq(5);
    fork
      begin
        t_reset();
        t_ctrl_write_and_poll();
        t_wiper_gate();
        t_wiper_write();
        t_ctrl_read();
        t_bad_type();
        t_reserved();
        t_abort();
      end
      begin
        repeat (150000) @(posedge clk);
        fails++;
        vectors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule